// File: doc/BRIEF.md
# TAP Configuration Loader

This block is a serial test access port controller whose instruction register decodes two instructions used to configure the chip. It contains the full sixteen-state port state machine, a five-bit instruction register and a one-bit bypass path. Under the load instruction, bits entering on the serial data input in the data-shift state are packed into 32-bit words. Each word goes out on a parallel port with a one-cycle valid strobe. Under the boot instruction, every test clock spent in the data-shift state advances a startup counter. A sticky done flag rises once the programmed number of clocks has passed.

A host first puts the load instruction in place and shifts the whole bitstream through the data-shift state. The stream may be split across several visits to that state. The host then returns to idle, loads the boot instruction, enters the data-shift state again and keeps clocking until done rises. An active-low program input holds the whole block in reset. The mode inputs raise a lock flag that tells the rest of the chip to shut out its other configuration ports. Loading through the test port stays possible whatever the mode inputs say.

Top module: `jtag_cfg_loader`

## Requirements
- R1: While rst_ni is low and just after it rises: the port state machine is in Test-Logic-Reset, the instruction is BYPASS (all ones), and tdo_o, tdo_en_o, cfg_valid_o, done_o and cfg_word_o are all zero.
- R2: Five test clocks with tms_i high bring the state machine to Test-Logic-Reset from any state, and that state puts the instruction back to BYPASS.
- R3: In the instruction-shift state, the register captures 5'b00001 and shifts it out least significant bit first, so tdo_o reads 1,0,0,0,0. Bits on tdi_i are taken in least significant bit first. The load code defaults to 5'b00101 and the boot code to 5'b01100.
- R4: tdo_en_o is high exactly while the state machine is in Shift-IR or Shift-DR.
- R5: tdo_o changes only on the falling edge of tck_i.
- R6: Under BYPASS, or any instruction other than load, tdo_o in Shift-DR repeats the bit on tdi_i at the previous rising edge. The first bit after Capture-DR is 0.
- R7: Under the load instruction, each rising edge in Shift-DR shifts tdi_i into a 32-bit word, most significant bit first. On the 32nd bit, cfg_word_o takes the word and cfg_valid_o is high for exactly one cycle.
- R8: The bit count survives leaving Shift-DR through the pause states and coming back. A word may be split across several visits, and only Test-Logic-Reset or rst_ni clears the count.
- R9: Under the boot instruction, done_o rises at the rising edge of the startup_len_i-th clock spent in Shift-DR. A length of 0 acts as 1. done_o then stays high until rst_ni goes low.
- R10: Clocks in Shift-DR under any other instruction, and clocks in any other state, do not advance the startup count.
- R11: While rst_ni is low, tms_i and tdi_i have no effect on any output or on the state found after release.
- R12: scan_lock_o is high exactly when mode_i[0]=1 and mode_i[1]=0, whatever mode_i[2] is. Configuration words are delivered for every mode_i value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low program reset, asynchronous |
| tms_i | input | 1 | Test mode select |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, updated on falling tck_i |
| tdo_en_o | output | 1 | Output enable for tdo_o |
| mode_i | input | 3 | Mode pins, bit 0 first |
| scan_lock_o | output | 1 | Other configuration ports locked out |
| startup_len_i | input | 8 | Startup length in tck_i cycles |
| cfg_word_o | output | 32 | Last assembled configuration word |
| cfg_valid_o | output | 1 | One-cycle strobe for cfg_word_o |
| done_o | output | 1 | Startup sequence complete |

## Verification
The hardest case to reach is a startup count that must keep its value across changes that should not touch it. Under BYPASS and under the load instruction, the bench shifts many bits first. It then loads the boot instruction, leaves Shift-DR partway through, sits in Pause-DR, and comes back. done_o must rise exactly on the programmed clock, counting the exit edge as a shift. Split words get the same treatment through Pause-DR. A long pseudo-random TMS walk, followed by a bench model of the state machine, covers every state for the output-enable check.

// File: rtl/jtag_cfg_pkg.sv
package jtag_cfg_pkg;
  typedef enum logic [3:0] {
    TLR    = 4'h0, RTI    = 4'h1, SEL_DR = 4'h2, CAP_DR = 4'h3,
    SH_DR  = 4'h4, EX1_DR = 4'h5, PAU_DR = 4'h6, EX2_DR = 4'h7,
    UPD_DR = 4'h8, SEL_IR = 4'h9, CAP_IR = 4'hA, SH_IR  = 4'hB,
    EX1_IR = 4'hC, PAU_IR = 4'hD, EX2_IR = 4'hE, UPD_IR = 4'hF
  } tap_state_e;
endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
  import jtag_cfg_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);
  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TLR:    state_d = tms_i ? TLR    : RTI;
      RTI:    state_d = tms_i ? SEL_DR : RTI;
      SEL_DR: state_d = tms_i ? SEL_IR : CAP_DR;
      CAP_DR: state_d = tms_i ? EX1_DR : SH_DR;
      SH_DR:  state_d = tms_i ? EX1_DR : SH_DR;
      EX1_DR: state_d = tms_i ? UPD_DR : PAU_DR;
      PAU_DR: state_d = tms_i ? EX2_DR : PAU_DR;
      EX2_DR: state_d = tms_i ? UPD_DR : SH_DR;
      UPD_DR: state_d = tms_i ? SEL_DR : RTI;
      SEL_IR: state_d = tms_i ? TLR    : CAP_IR;
      CAP_IR: state_d = tms_i ? EX1_IR : SH_IR;
      SH_IR:  state_d = tms_i ? EX1_IR : SH_IR;
      EX1_IR: state_d = tms_i ? UPD_IR : PAU_IR;
      PAU_IR: state_d = tms_i ? EX2_IR : PAU_IR;
      EX2_IR: state_d = tms_i ? UPD_IR : SH_IR;
      UPD_IR: state_d = tms_i ? SEL_DR : RTI;
      default: state_d = TLR;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= TLR;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/jtag_ir.sv
module jtag_ir
  import jtag_cfg_pkg::*;
#(
  parameter int unsigned IR_W = 5
) (
  input  logic            tck_i,
  input  logic            rst_ni,
  input  tap_state_e      state_i,
  input  logic            tdi_i,
  output logic [IR_W-1:0] ir_o,
  output logic            sr_lsb_o
);
  localparam logic [IR_W-1:0] CAPTURE_VAL = IR_W'(1);

  logic [IR_W-1:0] sr_q, ir_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
      ir_q <= '1;
    end else begin
      unique case (state_i)
        CAP_IR:  sr_q <= CAPTURE_VAL;
        SH_IR:   sr_q <= {tdi_i, sr_q[IR_W-1:1]};
        default: sr_q <= sr_q;
      endcase
      if (state_i == TLR)         ir_q <= '1;
      else if (state_i == UPD_IR) ir_q <= sr_q;
    end
  end

  assign ir_o     = ir_q;
  assign sr_lsb_o = sr_q[0];
endmodule

// File: rtl/cfg_word_shifter.sv
module cfg_word_shifter #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              shift_en_i,
  input  logic              clear_i,
  input  logic              tdi_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              msb_o
);
  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sr_q, word_q, sr_nx;
  logic [CNT_W-1:0]  cnt_q;
  logic              valid_q;

  assign sr_nx = {sr_q[WORD_W-2:0], tdi_i};

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      word_q  <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (clear_i) begin
        cnt_q <= '0;
      end else if (shift_en_i) begin
        sr_q <= sr_nx;
        if (cnt_q == LAST) begin
          cnt_q   <= '0;
          word_q  <= sr_nx;
          valid_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
  assign msb_o   = sr_q[WORD_W-1];
endmodule

// File: rtl/startup_seq.sv
module startup_seq #(
  parameter int unsigned LEN_W = 8
) (
  input  logic             tck_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             done_o
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W:0]   cnt_nx;
  logic             done_q;

  assign cnt_nx = {1'b0, cnt_q} + (LEN_W+1)'(1);

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (step_i && !done_q) begin
      cnt_q <= cnt_nx[LEN_W-1:0];
      if (cnt_nx >= {1'b0, len_i}) done_q <= 1'b1;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/jtag_cfg_loader.sv
module jtag_cfg_loader
  import jtag_cfg_pkg::*;
#(
  parameter int unsigned     IR_W      = 5,
  parameter int unsigned     WORD_W    = 32,
  parameter int unsigned     LEN_W     = 8,
  parameter logic [IR_W-1:0] LOAD_CODE = 5'b00101,
  parameter logic [IR_W-1:0] BOOT_CODE = 5'b01100
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              tms_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  output logic              tdo_en_o,
  input  logic [2:0]        mode_i,
  output logic              scan_lock_o,
  input  logic [LEN_W-1:0]  startup_len_i,
  output logic [WORD_W-1:0] cfg_word_o,
  output logic              cfg_valid_o,
  output logic              done_o
);
  tap_state_e      state_q;
  logic [IR_W-1:0] ir_q;
  logic            ir_lsb, cfg_msb, bypass_q;
  logic            load_sel, boot_sel;
  logic            tdo_d, tdo_q, tdo_en_d, tdo_en_q;
  logic            unused_mode;

  jtag_tap_fsm u_fsm (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .tms_i   (tms_i),
    .state_o (state_q)
  );

  jtag_ir #(.IR_W(IR_W)) u_ir (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .state_i  (state_q),
    .tdi_i    (tdi_i),
    .ir_o     (ir_q),
    .sr_lsb_o (ir_lsb)
  );

  assign load_sel = (ir_q == LOAD_CODE);
  assign boot_sel = (ir_q == BOOT_CODE);

  cfg_word_shifter #(.WORD_W(WORD_W)) u_word (
    .tck_i      (tck_i),
    .rst_ni     (rst_ni),
    .shift_en_i (state_q == SH_DR && load_sel),
    .clear_i    (state_q == TLR),
    .tdi_i      (tdi_i),
    .word_o     (cfg_word_o),
    .valid_o    (cfg_valid_o),
    .msb_o      (cfg_msb)
  );

  startup_seq #(.LEN_W(LEN_W)) u_boot (
    .tck_i  (tck_i),
    .rst_ni (rst_ni),
    .step_i (state_q == SH_DR && boot_sel),
    .len_i  (startup_len_i),
    .done_o (done_o)
  );

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                bypass_q <= 1'b0;
    else if (state_q == CAP_DR) bypass_q <= 1'b0;
    else if (state_q == SH_DR)  bypass_q <= tdi_i;
  end

  always_comb begin
    tdo_d    = 1'b0;
    tdo_en_d = 1'b0;
    if (state_q == SH_IR) begin
      tdo_d    = ir_lsb;
      tdo_en_d = 1'b1;
    end else if (state_q == SH_DR) begin
      tdo_d    = load_sel ? cfg_msb : bypass_q;
      tdo_en_d = 1'b1;
    end
  end

  // serial output launched on the falling edge
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_q    <= 1'b0;
      tdo_en_q <= 1'b0;
    end else begin
      tdo_q    <= tdo_d;
      tdo_en_q <= tdo_en_d;
    end
  end

  assign tdo_o       = tdo_q;
  assign tdo_en_o    = tdo_en_q;
  assign scan_lock_o = mode_i[0] & ~mode_i[1];
  assign unused_mode = mode_i[2];
endmodule

// File: rtl/jtag_cfg_loader_chk.sv
module jtag_cfg_loader_chk
  import jtag_cfg_pkg::*;
#(
  parameter int unsigned     IR_W      = 5,
  parameter logic [IR_W-1:0] LOAD_CODE = 5'b00101,
  parameter logic [IR_W-1:0] BOOT_CODE = 5'b01100
) (
  input logic            tck_i,
  input logic            rst_ni,
  input logic            tdo_en_o,
  input logic            cfg_valid_o,
  input logic            done_o,
  input tap_state_e      state_q,
  input logic [IR_W-1:0] ir_q
);
  assert_tdo_en_R4: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_en_o == (state_q == SH_IR || state_q == SH_DR));

  assert_tlr_bypass_R2: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == TLR && $past(state_q) == TLR) |-> ir_q == '1);

  assert_valid_pulse_R7: assert property (@(posedge tck_i) disable iff (!rst_ni)
    cfg_valid_o |=> !cfg_valid_o);

  assert_valid_source_R7: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $rose(cfg_valid_o) |-> $past(state_q == SH_DR && ir_q == LOAD_CODE));

  assert_done_sticky_R9: assert property (@(posedge tck_i) disable iff (!rst_ni)
    done_o |=> done_o);

  assert_done_source_R10: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(state_q == SH_DR && ir_q == BOOT_CODE));
endmodule

bind jtag_cfg_loader jtag_cfg_loader_chk #(
  .IR_W(IR_W), .LOAD_CODE(LOAD_CODE), .BOOT_CODE(BOOT_CODE)
) u_chk (.*);

// File: tb/tb_jtag_cfg_loader.sv
module tb_jtag_cfg_loader;
  import jtag_cfg_pkg::*;

  localparam int TCK_PERIOD = 10;
  localparam int H = TCK_PERIOD / 2;
  localparam logic [4:0] LOAD = 5'b00101;
  localparam logic [4:0] BOOT = 5'b01100;

  logic        tck_i = 1'b0, rst_ni = 1'b0, tms_i = 1'b0, tdi_i = 1'b0;
  logic        tdo_o, tdo_en_o, scan_lock_o, cfg_valid_o, done_o;
  logic [2:0]  mode_i = 3'b000;
  logic [7:0]  startup_len_i = 8'd1;
  logic [31:0] cfg_word_o;

  int vectors = 0, fails = 0;
  bit finished = 0;
  tap_state_e mst;

  jtag_cfg_loader dut (
    .tck_i(tck_i), .rst_ni(rst_ni), .tms_i(tms_i), .tdi_i(tdi_i),
    .tdo_o(tdo_o), .tdo_en_o(tdo_en_o), .mode_i(mode_i),
    .scan_lock_o(scan_lock_o), .startup_len_i(startup_len_i),
    .cfg_word_o(cfg_word_o), .cfg_valid_o(cfg_valid_o), .done_o(done_o)
  );

  function automatic tap_state_e nxt(tap_state_e s, logic m);
    case (s)
      TLR:    return m ? TLR    : RTI;
      RTI:    return m ? SEL_DR : RTI;
      SEL_DR: return m ? SEL_IR : CAP_DR;
      CAP_DR: return m ? EX1_DR : SH_DR;
      SH_DR:  return m ? EX1_DR : SH_DR;
      EX1_DR: return m ? UPD_DR : PAU_DR;
      PAU_DR: return m ? EX2_DR : PAU_DR;
      EX2_DR: return m ? UPD_DR : SH_DR;
      UPD_DR: return m ? SEL_DR : RTI;
      SEL_IR: return m ? TLR    : CAP_IR;
      CAP_IR: return m ? EX1_IR : SH_IR;
      SH_IR:  return m ? EX1_IR : SH_IR;
      EX1_IR: return m ? UPD_IR : PAU_IR;
      PAU_IR: return m ? EX2_IR : PAU_IR;
      EX2_IR: return m ? UPD_IR : SH_IR;
      default: return m ? SEL_DR : RTI;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clk(logic m, logic d);
    tms_i = m; tdi_i = d;
    #H tck_i = 1'b1;
    #H tck_i = 1'b0;
    #1;
    mst = nxt(mst, m);
  endtask

  task automatic clk_probe(logic m, logic d, output logic mid);
    tms_i = m; tdi_i = d;
    #H tck_i = 1'b1;
    #1 mid = tdo_o;
    #(H-1) tck_i = 1'b0;
    #1;
    mst = nxt(mst, m);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    for (int i = 0; i < 4; i++) clk(i[0], ~i[0]);
    rst_ni = 1'b1;
    mst = TLR;
    #1;
  endtask

  task automatic to_idle();
    for (int i = 0; i < 5; i++) clk(1, 0);
    clk(0, 0);
  endtask

  task automatic load_ir(logic [4:0] code);
    clk(1, 0); clk(1, 0); clk(0, 0); clk(0, 0);
    for (int i = 0; i < 5; i++) clk(i == 4, code[i]);
    clk(1, 0); clk(0, 0);
  endtask

  task automatic enter_dr();
    clk(1, 0); clk(0, 0); clk(0, 0);
  endtask

  task automatic send_word(logic [31:0] w, string req);
    enter_dr();
    for (int i = 31; i >= 0; i--) begin
      clk(i == 0, w[i]);
      if (i == 1) chk({req, " no strobe before bit 32"}, {31'b0, cfg_valid_o}, 32'd0);
    end
    chk({req, " strobe"}, {31'b0, cfg_valid_o}, 32'd1);
    chk({req, " word"}, cfg_word_o, w);
    clk(1, 0);
    chk("R7 strobe one cycle", {31'b0, cfg_valid_o}, 32'd0);
    clk(0, 0);
  endtask

  initial begin
    #(TCK_PERIOD * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic mid;
    logic [15:0] lfsr;
    mst = TLR;

    // R1 / R11: reset state, inputs ignored while held
    #3;
    for (int i = 0; i < 12; i++) begin
      clk(i % 3 != 0, 1);
      chk("R11 tdo_en in reset", {31'b0, tdo_en_o}, 32'd0);
    end
    rst_ni = 1'b1; mst = TLR; #1;
    chk("R1 tdo", {31'b0, tdo_o}, 0);
    chk("R1 tdo_en", {31'b0, tdo_en_o}, 0);
    chk("R1 valid", {31'b0, cfg_valid_o}, 0);
    chk("R1 done", {31'b0, done_o}, 0);
    chk("R1 word", cfg_word_o, 0);
    // state is TLR with BYPASS: one idle step then a bypass shift
    clk(0, 0); enter_dr();
    for (int i = 0; i < 8; i++) begin
      clk(0, i[0] ^ i[2]);
      chk("R1 R6 bypass after release", {31'b0, tdo_o}, {31'b0, i[0] ^ i[2]});
    end
    clk(1, 0); clk(1, 0); clk(0, 0);

    // R6: first bit after capture is 0, then one-bit delay
    enter_dr();
    chk("R6 capture zero", {31'b0, tdo_o}, 0);
    chk("R4 tdo_en in Shift-DR", {31'b0, tdo_en_o}, 1);
    clk(0, 0);
    clk_probe(0, 1, mid);
    chk("R5 held after rising edge", {31'b0, mid}, 0);
    chk("R5 updated after falling edge", {31'b0, tdo_o}, 1);
    clk_probe(0, 0, mid);
    chk("R5 held after rising edge", {31'b0, mid}, 1);
    chk("R5 updated after falling edge", {31'b0, tdo_o}, 0);
    clk(1, 0);
    chk("R4 tdo_en off in Exit1-DR", {31'b0, tdo_en_o}, 0);
    clk(1, 0); clk(0, 0);

    // R3: instruction capture shifted out LSB first
    clk(1, 0); clk(1, 0); clk(0, 0); clk(0, 0);
    chk("R3 capture bit0", {31'b0, tdo_o}, 1);
    for (int i = 1; i < 5; i++) begin
      clk(0, 1);
      chk("R3 capture bits", {31'b0, tdo_o}, 0);
    end
    clk(1, 1); clk(1, 0); clk(0, 0);

    // R7: word patterns under the load instruction
    load_ir(LOAD);
    send_word(32'hA5C3_0F96, "R7 mixed");
    send_word(32'hFFFF_FFFF, "R7 ones");
    send_word(32'h0000_0001, "R7 lsb");
    send_word(32'h8000_0000, "R7 msb");

    // R8: word split across a pause
    enter_dr();
    for (int i = 31; i >= 20; i--) clk(i == 20, i[0]);
    chk("R8 no strobe at split", {31'b0, cfg_valid_o}, 0);
    clk(0, 0); clk(0, 0); clk(0, 0);
    clk(1, 0); clk(0, 0);
    for (int i = 19; i >= 0; i--) clk(i == 0, i[0]);
    chk("R8 split strobe", {31'b0, cfg_valid_o}, 1);
    chk("R8 split word", cfg_word_o, 32'hAAAA_AAAA);
    clk(1, 0); clk(0, 0);

    // R12: lock flag for every mode; loading works in each
    for (int m = 0; m < 8; m++) begin
      mode_i = m[2:0]; #1;
      chk("R12 lock", {31'b0, scan_lock_o}, {31'b0, m[0] & ~m[1]});
      send_word(32'h1234_5678 ^ (m * 32'h0101_0101), "R12 any mode");
    end
    mode_i = 3'b000;

    // R2: five TMS high returns to TLR, which restores BYPASS
    clk(1, 0); clk(0, 0); clk(0, 0); clk(0, 1);
    for (int i = 0; i < 5; i++) clk(1, 0);
    clk(0, 0); enter_dr();
    clk(0, 1);
    chk("R2 bypass after TLR", {31'b0, tdo_o}, 1);
    clk(0, 0);
    chk("R2 bypass after TLR", {31'b0, tdo_o}, 0);
    to_idle();

    // R4: pseudo-random walk, bench model predicts the state
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      clk(lfsr[0] & (lfsr[3] | lfsr[5]), lfsr[7]);
      chk("R4 enable matches shift states", {31'b0, tdo_en_o},
          {31'b0, (mst == SH_IR || mst == SH_DR)});
      if (i % 97 == 0) begin
        for (int k = 0; k < 5; k++) clk(1, 0);
        chk("R2 model in TLR", {28'b0, mst}, {28'b0, TLR});
        chk("R2 enable low in TLR", {31'b0, tdo_en_o}, 0);
      end
    end

    // R9: startup length sweep
    foreach (startup_len_i[j]) ;
    for (int t = 0; t < 6; t++) begin
      int len, need;
      len = (t == 0) ? 0 : (t == 1) ? 1 : (t == 2) ? 2 : (t == 3) ? 5 : (t == 4) ? 13 : 200;
      need = (len == 0) ? 1 : len;
      do_reset();
      startup_len_i = len[7:0];
      clk(0, 0);
      load_ir(BOOT);
      enter_dr();
      chk("R9 not done on entry", {31'b0, done_o}, 0);
      for (int k = 1; k <= need + 2; k++) begin
        clk(0, 0);
        if (k >= need - 1)
          chk("R9 done timing", {31'b0, done_o}, {31'b0, k >= need});
      end
      to_idle();
      chk("R9 done sticky", {31'b0, done_o}, 1);
    end

    // R10: other instructions and pause states do not count
    do_reset();
    startup_len_i = 8'd6;
    clk(0, 0); enter_dr();
    for (int k = 0; k < 20; k++) clk(0, 1);
    clk(1, 0); clk(1, 0); clk(0, 0);
    load_ir(LOAD);
    send_word(32'hDEAD_BEEF, "R10 load word");
    chk("R10 no done under other instructions", {31'b0, done_o}, 0);
    load_ir(BOOT);
    enter_dr();
    clk(0, 0); clk(0, 0); clk(0, 0); clk(1, 0);
    for (int k = 0; k < 5; k++) clk(0, 0);
    chk("R10 pause does not count", {31'b0, done_o}, 0);
    clk(1, 0); clk(0, 0);
    chk("R10 re-entry edge does not count", {31'b0, done_o}, 0);
    clk(0, 0);
    chk("R10 fifth clock", {31'b0, done_o}, 0);
    clk(0, 0);
    chk("R10 sixth clock", {31'b0, done_o}, 1);
    do_reset();
    chk("R1 done cleared by reset", {31'b0, done_o}, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule